// File: doc/BRIEF.md
# Mode 0 Serial Peripheral Master

This block is a single-slave serial peripheral master that moves one byte out and one byte in during each transaction. The serial clock idles low, the incoming line is sampled on each rising serial clock edge and the outgoing line changes on each falling edge. The serial clock is derived from the system clock by a divider set at elaboration time. A small sequencer walks through three phases: idle, bit shifting, and a cleanup phase that keeps the select line low for one more half-period before releasing it.

The host side starts a transaction with a one-cycle start strobe that carries the byte to send. A busy flag stays high for the whole transaction. A one-cycle done pulse marks the end, and the received byte appears in the same cycle. The outgoing and incoming bytes use separate shift registers, so bits that arrive cannot disturb bits that are still waiting to go out.

Top module: `spim_mode0_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. While it is asserted, cs_n_o is 1, sclk_o is 0, busy_o is 0, done_o is 0 and rx_data_o is 0, with no clock edge needed.
- R2: A start_i sampled high while idle latches tx_data_i. From the next cycle cs_n_o is 0 and busy_o is 1, and mosi_o already carries bit 7 of the latched byte before the first rising edge of sclk_o.
- R3: sclk_o is low whenever cs_n_o is high. Each half-period of sclk_o lasts CLK_DIV system clock cycles. A transaction has exactly 8 rising edges.
- R4: Bits go out MSB first. mosi_o changes only in the cycle in which sclk_o falls, so it is stable while sclk_o is high.
- R5: miso_i is captured on each rising edge of sclk_o, MSB first. The first captured bit becomes bit 7 of rx_data_o.
- R6: After the eighth falling edge, cs_n_o stays low with sclk_o low for CLK_DIV more cycles. In total cs_n_o is low for 17*CLK_DIV cycles per transaction.
- R7: done_o is a one-cycle pulse. It occurs in the first cycle in which cs_n_o is high again and busy_o is low, and rx_data_o holds the new byte in that cycle.
- R8: A start_i strobe while busy_o is high is ignored. It neither changes the byte being sent nor starts a further transaction.
- R9: The transmitted byte equals the latched byte whatever data arrives on miso_i and whatever tx_data_i does after the start.
- R10: rx_data_o changes only in a cycle where done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| tx_data_i | input | 8 | Byte to send, latched with start_i |
| rx_data_o | output | 8 | Last received byte |
| busy_o | output | 1 | High while a transaction runs |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| cs_n_o | output | 1 | Active-low slave select |

## Verification
Assertions check on every cycle that the serial clock is low whenever select is high, that the outgoing line holds steady while the serial clock is high, and that done is a single cycle coinciding with the release of select. They also check that the received byte moves only with done and that the bit index and divider counter stay in range. The bench scenarios show the things a single-cycle property cannot: the exact half-period lengths, the count of 17*CLK_DIV select-low cycles, the bit order in both directions against an independent slave model, the rejection of a mid-transfer start, and the asynchronous effect of reset.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } spim_state_e;

endpackage

// File: rtl/spim_half_tick.sv
module spim_half_tick #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    generate
        if (CLK_DIV <= 1) begin : g_every_cycle
            // Half-period of one system clock: tick on every running cycle.
            assign tick_o = run_i;
        end else begin : g_counter
            localparam int unsigned CNT_W = $clog2(CLK_DIV);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (!run_i || cnt_q == CNT_LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick_o = run_i && (cnt_q == CNT_LAST);

            // R3: the half-period counter never passes its last value
            a_r3_count_in_range : assert property (
                @(posedge clk) disable iff (!rst_n)
                cnt_q <= CNT_LAST
            );

            // R3: the counter restarts from zero whenever it is not running
            a_r3_count_clear_idle : assert property (
                @(posedge clk) disable iff (!rst_n)
                !run_i |=> cnt_q == '0
            );
        end
    endgenerate

endmodule

// File: rtl/spim_shift_pair.sv
module spim_shift_pair #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    input  logic              sample_i,
    input  logic              miso_i,
    input  logic              capture_i,
    output logic              mosi_o,
    output logic [DATA_W-1:0] rx_data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] out;
    } sr_regs_t;

    sr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.tx = data_i;
        end else if (shift_i) begin
            r_d.tx = {r_q.tx[DATA_W-2:0], 1'b0};
        end
        if (sample_i) begin
            r_d.rx = {r_q.rx[DATA_W-2:0], miso_i};
        end
        if (capture_i) begin
            r_d.out = r_q.rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mosi_o    = r_q.tx[DATA_W-1];
    assign rx_data_o = r_q.out;

    // R9: sampling an incoming bit never moves the outgoing register
    a_r9_rx_leaves_tx : assert property (
        @(posedge clk) disable iff (!rst_n)
        (sample_i && !shift_i && !load_i) |=> $stable(r_q.tx)
    );

endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic run_o,
    output logic busy_o,
    output logic done_o,
    output logic sclk_o,
    output logic cs_n_o,
    output logic load_o,
    output logic shift_o,
    output logic sample_o,
    output logic capture_o
);

    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        spim_state_e      state;
        logic [BIT_W-1:0] bit_idx;
        logic             sclk;
        logic             cs_n;
        logic             done;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        load_o    = 1'b0;
        shift_o   = 1'b0;
        sample_o  = 1'b0;
        capture_o = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o      = 1'b1;
                    s_d.state   = ST_SHIFT;
                    s_d.bit_idx = '0;
                    s_d.cs_n    = 1'b0;
                    s_d.sclk    = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick_i) begin
                    s_d.sclk = ~s_q.sclk;
                    if (!s_q.sclk) begin
                        // rising edge: capture the incoming bit
                        sample_o = 1'b1;
                    end else if (s_q.bit_idx == BIT_LAST) begin
                        // last falling edge: go hold the select line
                        s_d.state = ST_HOLD;
                    end else begin
                        // falling edge: present the next outgoing bit
                        shift_o     = 1'b1;
                        s_d.bit_idx = s_q.bit_idx + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick_i) begin
                    capture_o = 1'b1;
                    s_d.state = ST_IDLE;
                    s_d.cs_n  = 1'b1;
                    s_d.done  = 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
                s_d.cs_n  = 1'b1;
                s_d.sclk  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_IDLE;
            s_q.bit_idx <= '0;
            s_q.sclk    <= 1'b0;
            s_q.cs_n    <= 1'b1;
            s_q.done    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.state != ST_IDLE);
    assign run_o  = busy_o;
    assign done_o = s_q.done;
    assign sclk_o = s_q.sclk;
    assign cs_n_o = s_q.cs_n;

    // R3: the serial clock rests low while the slave is deselected
    a_r3_idle_clock_low : assert property (
        @(posedge clk) disable iff (!rst_n)
        s_q.cs_n |-> !s_q.sclk
    );

    // R3: the bit index covers the byte and never runs past it
    a_r3_bit_in_range : assert property (
        @(posedge clk) disable iff (!rst_n)
        s_q.bit_idx <= BIT_LAST
    );

    // R6: select is only released from the hold phase with the clock low
    a_r6_release_after_hold : assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(s_q.cs_n) |-> ($past(s_q.state) == ST_HOLD) && !s_q.sclk
    );

    // R7: done lasts a single cycle
    a_r7_done_single : assert property (
        @(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done
    );

    // R7: done comes with select released and the machine idle
    a_r7_done_at_release : assert property (
        @(posedge clk) disable iff (!rst_n)
        s_q.done |-> s_q.cs_n && (s_q.state == ST_IDLE)
    );

    // R8: a start strobe during shifting does not restart or end the transfer
    a_r8_start_ignored : assert property (
        @(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_SHIFT && start_i) |=> s_q.state != ST_IDLE
    );

endmodule

// File: rtl/spim_mode0_ctrl.sv
module spim_mode0_ctrl #(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              cs_n_o
);

    logic run, tick;
    logic load, shift_tx, sample_rx, capture;

    spim_half_tick #(
        .CLK_DIV (CLK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    spim_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick),
        .run_o     (run),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .sclk_o    (sclk_o),
        .cs_n_o    (cs_n_o),
        .load_o    (load),
        .shift_o   (shift_tx),
        .sample_o  (sample_rx),
        .capture_o (capture)
    );

    spim_shift_pair #(
        .DATA_W (DATA_W)
    ) u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .data_i    (tx_data_i),
        .shift_i   (shift_tx),
        .sample_i  (sample_rx),
        .miso_i    (miso_i),
        .capture_i (capture),
        .mosi_o    (mosi_o),
        .rx_data_o (rx_data_o)
    );

    // R4: the outgoing bit holds while the serial clock is high
    a_r4_mosi_steady_high : assert property (
        @(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o)
    );

    // R10: the received byte moves only together with done
    a_r10_rx_holds : assert property (
        @(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rx_data_o)
    );

    // R2: a selected slave always means a running transaction
    a_r2_select_means_busy : assert property (
        @(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o
    );

endmodule

// File: tb/spim_mode0_ctrl_tb_top.sv
module spim_mode0_ctrl_tb_top;

    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       busy, done, sclk, mosi, cs_n;
    logic       miso = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spim_mode0_ctrl #(
        .CLK_DIV (D),
        .DATA_W  (8)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .tx_data_i (tx_data),
        .rx_data_o (rx_data),
        .busy_o    (busy),
        .done_o    (done),
        .sclk_o    (sclk),
        .mosi_o    (mosi),
        .miso_i    (miso),
        .cs_n_o    (cs_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset_state();
        chk(cs_n === 1'b1, "R1", "cs_n in reset", 32'(cs_n), 1);
        chk(sclk === 1'b0, "R1", "sclk in reset", 32'(sclk), 0);
        chk(busy === 1'b0, "R1", "busy in reset", 32'(busy), 0);
        chk(done === 1'b0, "R1", "done in reset", 32'(done), 0);
        chk(rx_data === 8'h00, "R1", "rx_data in reset", 32'(rx_data), 0);
    endtask

    // One full transaction against a behavioural mode 0 slave.
    // junk_at > 0 pulses start with another byte at that cycle of the transfer.
    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] slv, input int junk_at);
        int cyc = 0;
        int low_cnt = 1;
        int rises = 0;
        int hi_len = 0;
        int sidx = 6;
        bit prev_sclk = 1'b0;
        bit prev_mosi;
        bit hi_bad = 1'b0;
        bit mosi_bad = 1'b0;
        bit rx_moved = 1'b0;
        logic [7:0] got = 8'h00;
        logic [7:0] rx_before = rx_data;

        @(negedge clk);
        start = 1'b1;
        tx_data = tx;
        @(negedge clk);
        start = 1'b0;
        tx_data = ~tx;  // R9: changing the input after the start must not matter
        chk(cs_n === 1'b0 && busy === 1'b1, "R2", "select and busy after start",
            {30'd0, cs_n, busy}, 32'h1);
        chk(mosi === tx[7], "R2", "first bit before first rising edge", 32'(mosi), 32'(tx[7]));
        miso = slv[7];
        prev_mosi = mosi;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (junk_at > 0 && cyc == junk_at) begin
                start = 1'b1;
                tx_data = 8'h3C ^ tx;
            end else if (junk_at > 0 && cyc == junk_at + 1) begin
                start = 1'b0;
            end
            if (cs_n === 1'b0) low_cnt++;
            if (done !== 1'b1 && rx_data !== rx_before) rx_moved = 1'b1;
            if (sclk && !prev_sclk) begin
                rises++;
                got = {got[6:0], mosi};
                if (mosi !== prev_mosi) mosi_bad = 1'b1;
                hi_len = 1;
            end else if (sclk) begin
                hi_len++;
                if (mosi !== prev_mosi) mosi_bad = 1'b1;
            end else if (prev_sclk) begin
                if (hi_len != D) hi_bad = 1'b1;
                if (sidx >= 0) begin
                    miso = slv[sidx];
                    sidx--;
                end
            end
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
        chk(done === 1'b1, "R7", "done seen", 32'(done), 1);
        chk(cs_n === 1'b1 && busy === 1'b0, "R7", "released and idle with done",
            {30'd0, cs_n, busy}, 32'h2);
        chk(rx_data === slv, "R5", "received byte", 32'(rx_data), 32'(slv));
        chk(got === tx, "R4", "bits sent MSB first", 32'(got), 32'(tx));
        chk(!mosi_bad, "R4", "mosi stable while sclk high", 32'(mosi_bad), 0);
        chk(rises == 8, "R3", "rising edge count", 32'(rises), 8);
        chk(!hi_bad, "R3", "high half-period length", 32'(hi_bad), 0);
        chk(low_cnt == 17 * D, "R6", "select low cycles", 32'(low_cnt), 32'(17 * D));
        chk(!rx_moved, "R10", "rx_data held during transfer", 32'(rx_moved), 0);
        @(negedge clk);
        chk(done === 1'b0, "R7", "done one cycle wide", 32'(done), 0);
        chk(rx_data === slv, "R10", "rx_data held after done", 32'(rx_data), 32'(slv));
    endtask

    task automatic test_basic();
        run_xfer(8'hA5, 8'h5A, 0);
    endtask

    task automatic test_extremes();
        run_xfer(8'h00, 8'hFF, 0);
        run_xfer(8'hFF, 8'h00, 0);
    endtask

    task automatic test_independent_paths();
        // R9: same outgoing byte against different incoming patterns
        run_xfer(8'h81, 8'h7E, 0);
        run_xfer(8'h81, 8'hC3, 0);
    endtask

    task automatic test_start_while_busy();
        bit stayed_idle = 1'b1;
        run_xfer(8'h96, 8'h2D, 7);
        for (int i = 0; i < 4 * D; i++) begin
            @(negedge clk);
            if (cs_n !== 1'b1 || busy !== 1'b0) stayed_idle = 1'b0;
        end
        chk(stayed_idle, "R8", "no transfer started by mid-transfer strobe", 32'(stayed_idle), 1);
    endtask

    task automatic test_async_reset();
        @(negedge clk);
        start = 1'b1;
        tx_data = 8'hE7;
        @(negedge clk);
        start = 1'b0;
        repeat (5 * D) @(negedge clk);
        chk(cs_n === 1'b0, "R1", "transfer running before reset", 32'(cs_n), 0);
        #1;
        rst_n = 1'b0;
        #1;
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1",
            "async reset without clock edge", {29'd0, cs_n, sclk, busy}, 32'h4);
        chk(rx_data === 8'h00, "R1", "rx_data cleared by reset", 32'(rx_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_basic();
        test_extremes();
        test_independent_paths();
        test_start_while_busy();
        test_async_reset();
        test_basic();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule